// File: doc/BRIEF.md
# Conversion Result Buffer with Interrupt

This block collects finished analog-to-digital conversion results into a small register file and tells the processor when a programmed batch of results is ready. Each result arrives with a channel number and a one-cycle valid strobe. The block raises a sticky interrupt flag every time a programmed number of conversions, from 1 to 16, has been accepted. After each such event the next result is written at slot zero again.

There are two addressing modes. In sequential mode, results land in consecutive slots starting at zero. If the batch is longer than the buffer, the pointer wraps past the last slot back to zero. In channel mode, each result lands in the slot whose index is its channel number. The conversions are counted in the same way in both modes.

The interrupt request output is the flag gated by an enable input. Software reads the slots through an asynchronous read port and clears the flag with a clear strobe.

Top module: `adc_result_buffer`

## Requirements
- R1: After reset every slot reads 0, and both `intFlag` and `intReq` are 0.
- R2: The conversion target comes from the 5-bit `cfgCount` field. A value n from 0 to 15 means n+1 conversions. Any value from 16 to 31 means 16 conversions.
- R3: `intFlag` is 1 after the clock edge that accepts the target-th conversion since the last event or restart. The event then repeats after every further target conversions.
- R4: After an event, the next sequential write goes to slot 0. With `cfgCount` = 0, only slot 0 is ever written in sequential mode.
- R5: With `cfgChanMode` = 0, each accepted result goes to the slot after the previous one. The slot after DEPTH-1 is slot 0.
- R6: With `cfgChanMode` = 1, each accepted result goes to the slot equal to `resChan`. A channel number of DEPTH or above writes no slot but still counts.
- R7: `intReq` equals `intFlag` AND `intEnable`. The flag sets whether or not the enable is 1.
- R8: `intFlag` holds until a cycle with `flagClear` = 1 and no event. If `flagClear` and an event occur in the same cycle, the flag stays set.
- R9: A cycle whose `cfgCount` or `cfgChanMode` differs from the value held since the previous cycle restarts the pointer and the counter at zero. A result accepted in that cycle is the first of the new batch.
- R10: `rdData` shows the slot selected by `rdAddr` combinationally. A write becomes visible after the clock edge that accepts it. Slots that are not addressed keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| resValid | input | 1 | A conversion result is present this cycle |
| resData | input | DATA_W | Conversion result value |
| resChan | input | ADDR_W | Channel number of the result |
| cfgCount | input | 5 | Conversions per interrupt, minus one |
| cfgChanMode | input | 1 | 1 selects channel addressing, 0 selects sequential |
| intEnable | input | 1 | Lets the flag through to `intReq` |
| flagClear | input | 1 | Clears the interrupt flag |
| rdAddr | input | ADDR_W | Slot to read |
| rdData | output | DATA_W | Contents of the addressed slot |
| intFlag | output | 1 | Sticky batch-complete flag |
| intReq | output | 1 | Gated interrupt request |

## Verification
The assertions take the inputs to be free of X after reset. They also take a configuration change to take effect at once, in the same cycle it is driven, and not to be delayed by a pending result. The stimulus only moves inputs half a period away from the rising edge. Most configuration changes fall between batches. A small random share of changes, and one directed case, land in the middle of a batch and together with a result, so that the restart path is covered. Channel numbers are drawn over the full slot range, and the count field covers the encodings above 15.

// File: rtl/adc_result_buffer_pkg.sv
package adc_result_buffer_pkg;

  localparam int MaxDepth = 16;
  localparam int SlotIdxW = 4;
  localparam int CountW   = 5;

  typedef struct packed {
    logic                wrEn;
    logic [SlotIdxW-1:0] wrAddr;
  } bufStrobe_t;

  function automatic logic [CountW-1:0] countTarget(input logic [CountW-1:0] field);
    return (field >= CountW'(15)) ? CountW'(16) : field + CountW'(1);
  endfunction

endpackage

// File: rtl/adc_result_buffer_ctrl.sv
module adc_result_buffer_ctrl
  import adc_result_buffer_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     resValid,
  input  logic [ADDR_W-1:0]        resChan,
  input  logic [CountW-1:0]        cfgCount,
  input  logic                     cfgChanMode,
  input  logic                     flagClear,
  output bufStrobe_t               strobe,
  output logic                     intFlag
);

  logic [CountW-1:0] cfgCountQ;
  logic              cfgModeQ;
  logic [ADDR_W-1:0] wrPtr;
  logic [CountW-1:0] convCount;

  logic              cfgChange;
  logic [CountW-1:0] target;
  logic [CountW-1:0] targetQ;
  logic [ADDR_W-1:0] basePtr;
  logic [CountW-1:0] baseCnt;
  logic              batchDone;
  logic [ADDR_W-1:0] ptrInc;
  logic [ADDR_W-1:0] wrAddrSel;

  always_comb begin
    target    = countTarget(cfgCount);
    targetQ   = countTarget(cfgCountQ);
    cfgChange = (cfgCount != cfgCountQ) || (cfgChanMode != cfgModeQ);
    basePtr   = cfgChange ? '0 : wrPtr;
    baseCnt   = cfgChange ? '0 : convCount;
    batchDone = resValid && ((baseCnt + CountW'(1)) == target);
    ptrInc    = (basePtr == ADDR_W'(DEPTH - 1)) ? '0 : basePtr + ADDR_W'(1);
    wrAddrSel = cfgChanMode ? resChan : basePtr;
  end

  always_comb begin
    strobe        = '0;
    strobe.wrEn   = resValid;
    strobe.wrAddr = SlotIdxW'(wrAddrSel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgCountQ <= '0;
      cfgModeQ  <= 1'b0;
    end else begin
      cfgCountQ <= cfgCount;
      cfgModeQ  <= cfgChanMode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr     <= '0;
      convCount <= '0;
    end else if (batchDone) begin
      wrPtr     <= '0;
      convCount <= '0;
    end else if (resValid) begin
      wrPtr     <= ptrInc;
      convCount <= baseCnt + CountW'(1);
    end else begin
      wrPtr     <= basePtr;
      convCount <= baseCnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         intFlag <= 1'b0;
    else if (batchDone) intFlag <= 1'b1;
    else if (flagClear) intFlag <= 1'b0;
  end

  assert_count_below_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    convCount < targetQ);

  assert_restart_after_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    batchDone |=> (wrPtr == '0) && (convCount == '0));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    batchDone |=> intFlag);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (intFlag && !flagClear) |=> intFlag);

  assert_cfg_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgChange && !resValid) |=> (wrPtr == '0) && (convCount == '0));

endmodule

// File: rtl/adc_result_buffer_dp.sv
module adc_result_buffer_dp
  import adc_result_buffer_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 12,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bufStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam bit FullRange = (DEPTH == (1 << ADDR_W));

  logic [DATA_W-1:0] slots [DEPTH];
  logic [ADDR_W-1:0] wrIdx;

  assign wrIdx = strobe.wrAddr[ADDR_W-1:0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   slots[i] <= '0;
      else if (strobe.wrEn && wrIdx == ADDR_W'(i))  slots[i] <= wrData;
    end
  end

  if (FullRange) begin : g_rd_full
    assign rdData = slots[rdAddr];
  end else begin : g_rd_guard
    assign rdData = (int'(rdAddr) < DEPTH) ? slots[rdAddr] : '0;
  end

  assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrEn && int'(wrIdx) < DEPTH) |=> slots[$past(wrIdx)] == $past(wrData));

endmodule

// File: rtl/adc_result_buffer.sv
module adc_result_buffer
  import adc_result_buffer_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 12,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resValid,
  input  logic [DATA_W-1:0] resData,
  input  logic [ADDR_W-1:0] resChan,
  input  logic [4:0]        cfgCount,
  input  logic              cfgChanMode,
  input  logic              intEnable,
  input  logic              flagClear,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              intFlag,
  output logic              intReq
);

  bufStrobe_t strobe;

  adc_result_buffer_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .resValid(resValid), .resChan(resChan),
    .cfgCount(cfgCount), .cfgChanMode(cfgChanMode), .flagClear(flagClear),
    .strobe(strobe), .intFlag(intFlag)
  );

  adc_result_buffer_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(resData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  assign intReq = intFlag & intEnable;

  assert_req_follows_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (intEnable && $rose(intFlag)) |-> intReq);

endmodule

// File: tb/adc_result_buffer_tb.sv
module adc_result_buffer_tb;
  localparam int DEPTH = 8;
  localparam int DATA_W = 12;
  localparam int ADDR_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic resValid = 1'b0;
  logic [DATA_W-1:0] resData = '0;
  logic [ADDR_W-1:0] resChan = '0;
  logic [4:0] cfgCount = '0;
  logic cfgChanMode = 1'b0;
  logic intEnable = 1'b0;
  logic flagClear = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic intFlag, intReq;

  always #2 clk = ~clk;

  adc_result_buffer #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .resValid(resValid), .resData(resData),
    .resChan(resChan), .cfgCount(cfgCount), .cfgChanMode(cfgChanMode),
    .intEnable(intEnable), .flagClear(flagClear), .rdAddr(rdAddr),
    .rdData(rdData), .intFlag(intFlag), .intReq(intReq)
  );

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  int mMem [DEPTH];
  int mPtr = 0, mCnt = 0, mFlag = 0, mCfgQ = 0, mModeQ = 0;

  function automatic int targetOf(int field);
    return (field >= 15) ? 16 : field + 1;
  endfunction

  function automatic void modelStep(bit v, int d, int ch, int cfg, int mode, bit clr);
    int p, c;
    bit evt;
    bit chg;
    chg = (cfg != mCfgQ) || (mode != mModeQ);
    p = chg ? 0 : mPtr;
    c = chg ? 0 : mCnt;
    evt = 0;
    if (v) begin
      mMem[mode ? ch : p] = d;
      if (c + 1 == targetOf(cfg)) begin evt = 1; p = 0; c = 0; end
      else begin p = (p + 1) % DEPTH; c = c + 1; end
    end
    mPtr = p; mCnt = c;
    if (evt) mFlag = 1;
    else if (clr) mFlag = 0;
    mCfgQ = cfg; mModeQ = mode;
  endfunction

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkOutputs(string tag);
    check({tag, " flag"}, int'(intFlag), mFlag);
    check("R7 req", int'(intReq), mFlag & int'(intEnable));
    check({tag, " slot"}, int'(rdData), mMem[rdAddr]);
  endtask

  task automatic doCycle(string tag, bit v, int d, int ch, int cfg, int mode,
                         bit en, bit clr, int ra);
    @(negedge clk);
    resValid = v; resData = DATA_W'(d); resChan = ADDR_W'(ch);
    cfgCount = 5'(cfg); cfgChanMode = mode[0]; intEnable = en;
    flagClear = clr; rdAddr = ADDR_W'(ra);
    modelStep(v, d, ch, cfg, mode, clr);
    @(posedge clk);
    #1;
    checkOutputs(tag);
  endtask

  task automatic sweep(string tag, int cfg, int mode);
    for (int i = 0; i < DEPTH; i++) doCycle(tag, 0, 0, 0, cfg, mode, 1, 0, i);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mMem[i] = 0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset contents and flags
    check("R1 flag", int'(intFlag), 0);
    check("R1 req", int'(intReq), 0);
    sweep("R1", 0, 0);

    // R4: count 0, every result goes to slot 0 and sets the flag
    doCycle("R4", 1, 11, 0, 0, 0, 1, 0, 0);
    doCycle("R4", 1, 22, 0, 0, 0, 1, 1, 0);   // R8: clear and event together
    doCycle("R4", 1, 33, 0, 0, 0, 1, 0, 1);
    sweep("R4", 0, 0);
    doCycle("R8", 0, 0, 0, 0, 0, 1, 1, 0);    // clear alone drops the flag

    // R7: flag sets with enable low, request stays low
    doCycle("R7", 1, 44, 0, 0, 0, 0, 0, 0);
    doCycle("R7", 0, 0, 0, 0, 0, 1, 0, 0);
    doCycle("R8", 0, 0, 0, 0, 0, 0, 1, 0);

    // R5, R3: 16 conversions wrap around the 8-slot buffer
    for (int i = 0; i < 16; i++) doCycle("R5", 1, 100 + i, 0, 15, 0, 1, 0, i % DEPTH);
    sweep("R5", 15, 0);
    doCycle("R3", 0, 0, 0, 15, 0, 1, 1, 0);
    // R2: encoding 20 means 16 conversions too
    for (int i = 0; i < 17; i++) doCycle("R2", 1, 200 + i, 0, 20, 0, 1, 0, 0);

    // R6: channel addressing
    doCycle("R6", 0, 0, 0, 3, 1, 1, 1, 0);
    doCycle("R6", 1, 300, 5, 3, 1, 1, 0, 5);
    doCycle("R6", 1, 301, 2, 3, 1, 1, 0, 2);
    doCycle("R6", 1, 302, 7, 3, 1, 1, 0, 7);
    doCycle("R6", 1, 303, 2, 3, 1, 1, 0, 2);
    sweep("R6", 3, 1);

    // R9: change count mid-batch together with a result
    doCycle("R9", 0, 0, 0, 2, 0, 1, 1, 0);
    doCycle("R9", 1, 400, 0, 2, 0, 1, 0, 0);
    doCycle("R9", 1, 401, 0, 2, 0, 1, 0, 1);
    doCycle("R9", 1, 402, 0, 1, 0, 1, 0, 0);
    doCycle("R9", 1, 403, 0, 1, 0, 1, 0, 1);
    sweep("R9", 1, 0);

    // Random phases
    for (int ph = 0; ph < 8; ph++) begin
      int cfg = $urandom_range(31);
      int mode = $urandom_range(1);
      for (int k = 0; k < 400; k++) begin
        if ($urandom_range(99) == 0) cfg = $urandom_range(31);
        if ($urandom_range(199) == 0) mode = $urandom_range(1);
        doCycle("R10", $urandom_range(99) < 60, $urandom_range(4095),
                $urandom_range(DEPTH - 1), cfg, mode, $urandom_range(1),
                $urandom_range(9) == 0, $urandom_range(DEPTH - 1));
      end
    end
    finish();
  end
endmodule